// File: doc/BRIEF.md
# Repeating Fractional Multiply-Accumulate Sequencer

This block runs a repeated multiply-accumulate loop over two streams of 16-bit signed fractions. A start pulse loads a 16-bit loop count, the two operand registers (H and I) and the 36-bit accumulator. In each pass the sequencer multiplies H by I, shifts the product left by one, sign-extends it to 36 bits and adds it into the accumulator. It then pulses a request that asks an external index unit to advance its pointers. Next it reads a new H word from the X stream and a new I word from the Y stream through a single memory read port with a request and acknowledge handshake. Last, it decrements the count and tests it.

The count is decremented before it is tested, so the loop always runs at least once. A hold input can freeze the sequence at any step, for example while an exception is being serviced, and the loop resumes exactly where it stopped once hold is released. When the last test is done, a one-cycle done pulse marks the end of the run and busy falls. The operand registers keep the words fetched last.

Top module: `rmac_seq`

## Requirements
- R1: After synchronous reset, busy, done, mem_req and idx_step are low and h_q, i_q and acc_q are zero.
- R2: A start pulse seen while idle and not held loads cnt_in, h_init, i_init and acc_init and sets busy in the next cycle. A start seen while busy is ignored and does not alter the run in progress.
- R3: Each pass runs its steps in a fixed order. First comes one accumulate cycle with idx_step high. Then H is read with mem_sel=0 (X stream), then I with mem_sel=1 (Y stream), then the count is decremented and tested.
- R4: During a read, mem_req stays high and mem_sel stays stable until a cycle with mem_ack high. The word on mem_rdata in that cycle is loaded into the selected operand register.
- R5: The accumulate step adds 2·(H×I) to acc_q, where H×I is the signed 16×16 product, sign-extended to 36 bits. The addition wraps modulo 2^36.
- R6: When H and I both hold 16'h8000, the accumulate step adds exactly 36'h0_8000_0000 (+1.0).
- R7: A count N in 0..16'h7FFF gives N+1 passes. Any negative count other than 16'h8000 gives one pass. After the run, cnt_q reads 16'hFFFF for a non-negative start, and the start value minus one for a negative start.
- R8: A start count of 16'h8000 gives exactly 32770 passes and leaves cnt_q at 16'hFFFF.
- R9: After done, h_q and i_q hold the last words read from the X and Y streams, and they keep those words until the next start.
- R10: While hold is high, mem_req and idx_step are low, and acc_q, h_q, i_q and cnt_q do not change. The final result of a run is the same with or without hold cycles.
- R11: done is high for exactly one cycle, in the first cycle in which busy is low after the final count test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a new run |
| hold | input | 1 | Freezes the sequence while high |
| cnt_in | input | 16 | Loop count loaded at start |
| h_init | input | 16 | Initial H operand |
| i_init | input | 16 | Initial I operand |
| acc_init | input | 36 | Initial accumulator value |
| mem_ack | input | 1 | Read data valid for the current request |
| mem_rdata | input | 16 | Read data word |
| mem_req | output | 1 | Read request |
| mem_sel | output | 1 | Stream of the read: 0 = X (H), 1 = Y (I) |
| idx_step | output | 1 | Asks the index unit to advance, one cycle per pass |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| h_q | output | 16 | H operand register |
| i_q | output | 16 | I operand register |
| acc_q | output | 36 | Accumulator |
| cnt_q | output | 16 | Loop count register (low 16 bits) |

## Verification
A wrong step order or a lost handshake shows up within one pass: the operand registers take the wrong stream's word, or the index pointer drifts, so the accumulated sum differs at done. A wrong count test changes the number of idx_step pulses and the final cnt_q, and this becomes visible at the done pulse. A hold leak shows up at once as a change in acc_q, h_q, i_q or cnt_q, or as a request issued during a frozen cycle.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

    localparam int unsigned OP_W  = 16;
    localparam int unsigned ACC_W = 36;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MAC  = 3'd1,
        ST_RDX  = 3'd2,
        ST_RDY  = 3'd3,
        ST_CNT  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic load;
        logic mac;
        logic take_h;
        logic take_i;
        logic step_cnt;
    } seq_ctl_t;

    // Doubled signed product of two fractions, sign-extended to the accumulator width.
    function automatic logic [ACC_W-1:0] frac_term(input logic [OP_W-1:0] a,
                                                   input logic [OP_W-1:0] b);
        logic signed [2*OP_W-1:0]  prod;
        logic signed [ACC_W-1:0]   wide;
        prod = $signed(a) * $signed(b);
        wide = ACC_W'(prod);
        return ACC_W'(wide <<< 1);
    endfunction

endpackage

// File: rtl/rmac_mul.sv
module rmac_mul
    import rmac_pkg::*;
#(
    parameter int unsigned DW = OP_W,
    parameter int unsigned AW = ACC_W
) (
    input  logic [DW-1:0] op_h,
    input  logic [DW-1:0] op_i,
    output logic [AW-1:0] term
);
    localparam logic [DW-1:0] MIN_NEG  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [AW-1:0] PLUS_ONE = AW'({1'b1, {(2*DW-1){1'b0}}});

    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   prod_ext;

    always_comb begin
        prod     = $signed(op_h) * $signed(op_i);
        prod_ext = AW'(prod);
        if (op_h == MIN_NEG && op_i == MIN_NEG) begin
            term = PLUS_ONE;
        end else begin
            term = AW'(prod_ext <<< 1);
        end
    end
endmodule

// File: rtl/rmac_cnt.sv
module rmac_cnt
    import rmac_pkg::*;
#(
    parameter int unsigned DW = OP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] cnt_in,
    output logic          last,
    output logic [DW-1:0] cnt_q
);
    localparam int unsigned CW = DW + 1;
    localparam logic [DW-1:0] MIN_NEG   = {1'b1, {(DW-1){1'b0}}};
    localparam logic [CW-1:0] MIN_LOAD  = {2'b01, {(DW-2){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_r;
    logic [CW-1:0] cnt_dec;
    logic [CW-1:0] load_val;

    always_comb begin
        cnt_dec  = cnt_r - CW'(1);
        last     = cnt_dec[CW-1];
        load_val = (cnt_in == MIN_NEG) ? MIN_LOAD : {cnt_in[DW-1], cnt_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_r <= '0;
        end else if (load) begin
            cnt_r <= load_val;
        end else if (step) begin
            cnt_r <= cnt_dec;
        end
    end

    assign cnt_q = cnt_r[DW-1:0];
endmodule

// File: rtl/rmac_ctrl.sv
module rmac_ctrl
    import rmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       hold,
    input  logic       mem_ack,
    input  logic       last,
    output seq_ctl_t   ctl,
    output logic       mem_req,
    output logic       mem_sel,
    output logic       busy,
    output logic       done
);
    seq_state_e st_q, st_d;
    logic       done_d;

    always_comb begin
        st_d   = st_q;
        ctl    = '0;
        done_d = 1'b0;
        if (!hold) begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    ctl.load = 1'b1;
                    st_d     = ST_MAC;
                end
                ST_MAC: begin
                    ctl.mac = 1'b1;
                    st_d    = ST_RDX;
                end
                ST_RDX: if (mem_ack) begin
                    ctl.take_h = 1'b1;
                    st_d       = ST_RDY;
                end
                ST_RDY: if (mem_ack) begin
                    ctl.take_i = 1'b1;
                    st_d       = ST_CNT;
                end
                ST_CNT: begin
                    ctl.step_cnt = 1'b1;
                    if (last) begin
                        st_d   = ST_IDLE;
                        done_d = 1'b1;
                    end else begin
                        st_d = ST_MAC;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st_q <= st_d;
            done <= done_d;
        end
    end

    assign mem_req = !hold && (st_q == ST_RDX || st_q == ST_RDY);
    assign mem_sel = (st_q == ST_RDY);
    assign busy    = (st_q != ST_IDLE);
endmodule

// File: rtl/rmac_seq.sv
module rmac_seq
    import rmac_pkg::*;
#(
    parameter int unsigned DW = OP_W,
    parameter int unsigned AW = ACC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          hold,
    input  logic [DW-1:0] cnt_in,
    input  logic [DW-1:0] h_init,
    input  logic [DW-1:0] i_init,
    input  logic [AW-1:0] acc_init,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_sel,
    output logic          idx_step,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] h_q,
    output logic [DW-1:0] i_q,
    output logic [AW-1:0] acc_q,
    output logic [DW-1:0] cnt_q
);
    seq_ctl_t      ctl;
    logic          last;
    logic [AW-1:0] term;
    logic [DW-1:0] h_r, i_r;
    logic [AW-1:0] acc_r;

    rmac_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .hold    (hold),
        .mem_ack (mem_ack),
        .last    (last),
        .ctl     (ctl),
        .mem_req (mem_req),
        .mem_sel (mem_sel),
        .busy    (busy),
        .done    (done)
    );

    rmac_cnt #(.DW(DW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.load),
        .step   (ctl.step_cnt),
        .cnt_in (cnt_in),
        .last   (last),
        .cnt_q  (cnt_q)
    );

    rmac_mul #(.DW(DW), .AW(AW)) u_mul (
        .op_h (h_r),
        .op_i (i_r),
        .term (term)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            h_r   <= '0;
            i_r   <= '0;
            acc_r <= '0;
        end else begin
            if (ctl.load) begin
                h_r   <= h_init;
                i_r   <= i_init;
                acc_r <= acc_init;
            end
            if (ctl.mac)    acc_r <= acc_r + term;
            if (ctl.take_h) h_r   <= mem_rdata;
            if (ctl.take_i) i_r   <= mem_rdata;
        end
    end

    assign idx_step = ctl.mac;
    assign h_q      = h_r;
    assign i_q      = i_r;
    assign acc_q    = acc_r;
endmodule

// File: rtl/rmac_seq_chk.sv
module rmac_seq_chk #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          hold,
    input logic          mem_ack,
    input logic [DW-1:0] mem_rdata,
    input logic          mem_req,
    input logic          mem_sel,
    input logic          idx_step,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] h_q,
    input logic [DW-1:0] i_q,
    input logic [AW-1:0] acc_q,
    input logic [DW-1:0] cnt_q
);
    localparam logic [DW-1:0] NEG1 = {1'b1, {(DW-1){1'b0}}};
    localparam logic [AW-1:0] ONE  = AW'({1'b1, {(2*DW-1){1'b0}}});

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !idx_step));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !hold) |=> busy);

    p_step_then_x_r3: assert property (@(posedge clk) disable iff (rst)
        idx_step |=> (busy && !mem_sel));

    p_x_then_y_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_sel) |=> mem_sel);

    p_h_from_bus_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_sel) |=> (h_q == $past(mem_rdata)));

    p_i_from_bus_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_sel) |=> (i_q == $past(mem_rdata)));

    p_req_waits_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (busy && $stable(mem_sel)));

    p_plus_one_r6: assert property (@(posedge clk) disable iff (rst)
        (idx_step && h_q == NEG1 && i_q == NEG1) |=> (acc_q == $past(acc_q) + ONE));

    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        hold |-> (!mem_req && !idx_step));

    p_hold_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (hold && busy) |=> ($stable(acc_q) && $stable(h_q) && $stable(i_q) && $stable(cnt_q)));

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind rmac_seq rmac_seq_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/rmac_seq_bench.sv
module rmac_seq_bench;
    localparam int DW = 16;
    localparam int AW = 36;

    typedef struct {
        logic [AW-1:0] acc;
        logic [DW-1:0] h;
        logic [DW-1:0] i;
        logic [DW-1:0] cnt;
        int            iters;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          hold;
    logic [DW-1:0] cnt_in = '0, h_init = '0, i_init = '0;
    logic [AW-1:0] acc_init = '0;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;
    logic          mem_req, mem_sel, idx_step, busy, done;
    logic [DW-1:0] h_q, i_q, cnt_q;
    logic [AW-1:0] acc_q;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    logic       man_hold = 1'b0, ack_off = 1'b0, mode_wait = 1'b0, mode_hold = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    int         kx = 0;
    int         iters_seen = 0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] xword(int j);
        return DW'(j * 16'h3A7 + 16'h1357);
    endfunction
    function automatic logic [DW-1:0] yword(int j);
        return DW'(j * 16'h0B39 ^ 16'hA5C3);
    endfunction

    assign hold      = man_hold | (mode_hold & (lfsr[3:2] == 2'b00));
    assign mem_ack   = mem_req & !ack_off & (!mode_wait | lfsr[0]);
    assign mem_rdata = mem_sel ? yword(kx) : xword(kx);

    rmac_seq u_rmac_seq (
        .clk(clk), .rst(rst), .start(start), .hold(hold),
        .cnt_in(cnt_in), .h_init(h_init), .i_init(i_init), .acc_init(acc_init),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_sel(mem_sel), .idx_step(idx_step), .busy(busy), .done(done),
        .h_q(h_q), .i_q(i_q), .acc_q(acc_q), .cnt_q(cnt_q)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Stimulus-side pointer, iteration count and scoreboard monitor.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        #1;
        if (start && !busy && !hold) begin
            kx = 0;
            iters_seen = 0;
        end
        if (idx_step) begin
            kx++;
            iters_seen++;
        end
        if (done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R11", "done without run", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(acc_q == e.acc, "R5", "accumulator", acc_q, e.acc);
                check(h_q == e.h, "R9", "last H", h_q, e.h);
                check(i_q == e.i, "R9", "last I", i_q, e.i);
                check(cnt_q == e.cnt, "R7", "final count", cnt_q, e.cnt);
                check(iters_seen == e.iters, "R7/R8 passes", "iterations",
                      iters_seen, e.iters);
                check(!busy, "R11", "busy low with done", busy, 0);
            end
        end
    end

    // Driver: compute expectation from the requirements, push it, start the run.
    task automatic run(input logic [DW-1:0] c, input logic [DW-1:0] h0,
                       input logic [DW-1:0] i0, input logic [AW-1:0] a0,
                       input bit wait_for_end);
        exp_t  e;
        int    n;
        longint p;
        logic [DW-1:0] h, i;
        logic [AW-1:0] a;
        if (c == 16'h8000)     n = 32770;
        else if (c[DW-1])      n = 1;
        else                   n = int'(c) + 1;
        h = h0; i = i0; a = a0;
        for (int j = 1; j <= n; j++) begin
            p = longint'($signed(h)) * longint'($signed(i)) * 2;
            a = a + AW'(p);
            h = xword(j);
            i = yword(j);
        end
        e.acc = a; e.h = h; e.i = i; e.iters = n;
        e.cnt = c[DW-1] && c != 16'h8000 ? DW'(c - 1) : 16'hFFFF;
        sb_q.push_back(e);
        @(negedge clk);
        cnt_in = c; h_init = h0; i_init = i0; acc_init = a0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (man_hold || hold) @(negedge clk);
        if (wait_for_end) begin
            while (sb_q.size() != 0) @(negedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", "run timed out", 0, 1);
        report();
    end

    initial begin
        logic [AW-1:0] a_snap;
        logic [DW-1:0] h_snap, i_snap, c_snap;
        logic          s_snap;
        bit            ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        // R1: reset state
        check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        check(!mem_req && !idx_step, "R1", "req/step after reset", {mem_req, idx_step}, 0);
        check(acc_q == 0 && h_q == 0 && i_q == 0, "R1", "registers after reset", acc_q, 0);

        // R7 zero count: one pass, 0.5*0.5 adds 0.25 (36'h0_2000_0000)
        run(16'h0000, 16'h4000, 16'h4000, 36'h0, 1'b1);
        check(acc_q == 36'h0_2000_0000 + 0, "R5", "0.5*0.5 then no further add", acc_q, 36'h020000000);

        // R5 several passes, negative operands, wrap of accumulator
        run(16'h0003, 16'hC000, 16'h4000, 36'hF_FFFF_FFF0, 1'b1);
        run(16'h0006, 16'h7FFF, 16'h8001, 36'h1_0000_0000, 1'b1);

        // R7 negative count other than the minimum: one pass
        run(16'hFFF0, 16'h1234, 16'hFEDC, 36'h0, 1'b1);

        // R6 minus one times minus one adds +1.0
        run(16'hFFFF, 16'h8000, 16'h8000, 36'h0_0000_0011, 1'b1);
        check(acc_q[35:0] != 36'h0, "R6", "accumulator nonzero after +1.0", acc_q, 36'h080000011);

        // R2 start is ignored while busy
        run(16'h0004, 16'h2222, 16'h3333, 36'h5, 1'b0);
        repeat (3) @(negedge clk);
        cnt_in = 16'h0100; h_init = 16'h7777; acc_init = 36'hABC; start = 1'b1;
        @(negedge clk); start = 1'b0; #2;
        check(busy, "R2", "busy after extra start", busy, 1);
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk); #2;
        check(!busy, "R2", "no restart from ignored start", busy, 0);

        // R9 operands keep their values after done
        h_snap = h_q; i_snap = i_q;
        repeat (5) @(negedge clk); #2;
        check(h_q == h_snap && i_q == i_snap, "R9", "operands stable while idle", h_q, h_snap);

        // R4 request held until acknowledge
        ack_off = 1'b1;
        run(16'h0002, 16'h0100, 16'h0200, 36'h0, 1'b0);
        while (!mem_req) @(negedge clk);
        #2;
        h_snap = h_q; s_snap = mem_sel;
        ok = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #2;
            if (!mem_req || mem_sel != s_snap || h_q != h_snap) ok = 1'b0;
        end
        check(ok, "R4", "request waits for ack", {mem_req, mem_sel}, {1'b1, s_snap});
        ack_off = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);

        // R10 explicit hold window in the middle of a run
        run(16'h0005, 16'h1111, 16'h2222, 36'h0, 1'b0);
        repeat (6) @(negedge clk);
        man_hold = 1'b1;
        #2;
        a_snap = acc_q; h_snap = h_q; i_snap = i_q; c_snap = cnt_q;
        ok = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #2;
            if (mem_req || idx_step || acc_q != a_snap || h_q != h_snap ||
                i_q != i_snap || cnt_q != c_snap || !busy) ok = 1'b0;
        end
        check(ok, "R10", "outputs frozen under hold", acc_q, a_snap);
        man_hold = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);

        // R10 and R4: random holds and wait states give the same result
        mode_wait = 1'b1; mode_hold = 1'b1;
        run(16'h0009, 16'hF00F, 16'h0FF0, 36'h7_0000_0000, 1'b1);
        mode_wait = 1'b0; mode_hold = 1'b0;

        // R11 done is a single pulse
        run(16'h0001, 16'h0001, 16'h0001, 36'h0, 1'b0);
        while (!done) @(negedge clk);
        @(negedge clk); #2;
        check(!done, "R11", "done lasts one cycle", done, 0);

        // R8 minimum count gives 32770 passes
        run(16'h8000, 16'h0400, 16'h0800, 36'h0, 1'b1);

        check(sb_q.size() == 0, "R11", "all runs ended", sb_q.size(), 0);
        report();
    end
endmodule